// File: doc/BRIEF.md
# Slow-Clock Wakeup Timer and Watchdog

This block runs two up-counters on the slow always-on clock. The first is a wakeup timer. It is armed when the power controller goes from the active state to the power-down state, or when software issues a start command. Once armed, it counts slow clock cycles until the count reaches a programmed threshold. At that point it raises a wake request. The second is a watchdog counter. It is enabled out of reset and counts against its own threshold, which sits in a sub-field of its configuration word. When the count reaches that threshold, it raises a watchdog request.

Both requests are sticky. Each stays high until software writes its dedicated clear bit. The clear also restarts the matching counter from zero. Software reaches the block through a simple write port made of a strobe, a word select and a 32-bit data word. Through this port it sets each threshold and enable, and it commands start, stop and load-to-two for the wakeup timer. Both counts and both requests are visible at the ports for the interrupt logic that follows.

Top module: `lp_wake_timer`

## Requirements
- R1: After reset, wakeReq and wdogReq are 0, and wakeCount and wdogCount are 0.
- R2: A pwrState change from ACTIVE (3'b011) in one cycle to power-down (3'b000) in the next arms the wakeup timer. When the timer is armed and the wake enable is set (bit 31 of select 0), wakeCount rises by one each clock. The wake threshold is bits 30:0 of select 0.
- R3: A change into power-down from any state other than ACTIVE (for example 3'b100 to 3'b000) does not arm the wakeup timer, so wakeCount stays put.
- R4: Once wakeCount is at or above the effective threshold, the next clock sets wakeReq. The count then holds, and wakeReq stays set until it is cleared.
- R5: A threshold programmed below 2 is treated as 2.
- R6: A write to select 2 with bit 0 set clears wakeReq and sets wakeCount to 0. If the timer is still armed, counting resumes on the following clocks.
- R7: A write to select 1 with bit 16 set loads wakeCount with 2.
- R8: A write to select 1 with bit 2 set arms the timer. A write to select 1 with bit 3 set disarms it, after which wakeCount holds. If both bits are set in the same write, the stop wins.
- R9: The watchdog is enabled out of reset with a threshold of 0xEA6. Its enable is bit 31 of select 3 and its threshold is bits 30:8. wdogReq sets one clock after wdogCount reaches 3750.
- R10: A write to select 4 with bit 0 set clears wdogReq and sets wdogCount to 0.
- R11: When the watchdog enable is 0, wdogCount holds.
- R12: When the wake enable is 0, wakeCount holds even while the timer is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pwrState | input | 3 | Current state of the power controller |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register word select (0 to 4) |
| wrData | input | 32 | Register write data |
| wakeReq | output | 1 | Sticky wakeup timer request |
| wdogReq | output | 1 | Sticky watchdog request |
| wakeCount | output | 31 | Wakeup timer count |
| wdogCount | output | 23 | Watchdog count |

## Verification
The wakeup timer is driven with four kinds of power-state sequence and command pattern:
- A non-active entry into power-down, which shows that only the true active-to-down edge arms the timer.
- A real entry, which shows the count and request timing at the threshold.
- A stop/load/start pattern, which tells apart counting that is held, counting that is reloaded and counting that resumes.
- A zero threshold, which separates clamped behaviour from unclamped.

The watchdog is run from reset to its default threshold, then cleared and then disabled. This shows that reset enables it, that the clear restarts it, and that the enable freezes it. A behavioural model is compared with the outputs on every clock, so the timing of each rule is checked as well as its final values.

// File: rtl/lp_wake_pkg.sv
package lp_wake_pkg;

  // Register word selects
  localparam logic [2:0] SEL_WAKE_CFG = 3'd0;
  localparam logic [2:0] SEL_TMR_CTL  = 3'd1;
  localparam logic [2:0] SEL_WAKE_CLR = 3'd2;
  localparam logic [2:0] SEL_WDOG_CFG = 3'd3;
  localparam logic [2:0] SEL_WDOG_CLR = 3'd4;

  // Power controller state codes
  localparam logic [2:0] ST_PWRDN  = 3'b000;
  localparam logic [2:0] ST_ACTIVE = 3'b011;
  localparam logic [2:0] ST_SLEEP  = 3'b100;

  // Command bit order inside the control slice
  localparam int CMD_CLR   = 0;
  localparam int CMD_START = 1;
  localparam int CMD_STOP  = 2;
  localparam int CMD_LOAD  = 3;

  typedef struct packed {
    logic wakeCfgWr;
    logic wdogCfgWr;
    logic wakeClr;
    logic wdogClr;
    logic wakeLoad;
    logic wakeRun;
  } strobeT;

endpackage

// File: rtl/lp_cnt_unit.sv
module lp_cnt_unit #(
  parameter int W = 31,
  parameter int MIN_THR = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         en,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] thr,
  output logic [W-1:0] cnt,
  output logic         req
);
  localparam logic [W-1:0] FLOOR = W'(MIN_THR);

  logic [W-1:0] thrEff;
  assign thrEff = (thr < FLOOR) ? FLOOR : thr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      req <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      req <= 1'b0;
    end else if (load) begin
      cnt <= FLOOR;
    end else if (en && !req) begin
      if (cnt >= thrEff) req <= 1'b1;
      else               cnt <= cnt + W'(1);
    end
  end

  // R4: request is sticky until cleared
  a_r4_sticky_req: assert property (@(posedge clk) disable iff (!rstN)
    req && !clr |=> req);
  // R6 / R10: clear zeroes count and request
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (cnt == '0) && !req);
  // R7: load forces the floor value
  a_r7_load_two: assert property (@(posedge clk) disable iff (!rstN)
    load && !clr |=> cnt == FLOOR);
  // R11 / R12: without enable the count holds
  a_r12_hold_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !en && !clr && !load |=> $stable(cnt));
  // R4: count holds once the request has risen
  a_r4_hold_at_match: assert property (@(posedge clk) disable iff (!rstN)
    $rose(req) |-> $stable(cnt));
endmodule

// File: rtl/lp_wake_ctrl.sv
module lp_wake_ctrl
  import lp_wake_pkg::*;
#(
  parameter int STATE_W = 3,
  parameter int SEL_W = 3,
  parameter int CMD_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STATE_W-1:0] pwrState,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [CMD_W-1:0]   cmdBits,
  output strobeT             stb
);
  logic [STATE_W-1:0] prevState;
  logic runQ;
  logic pdEntry, startCmd, stopCmd, ctlWr;

  assign ctlWr    = wrEn && (wrSel == SEL_TMR_CTL);
  assign startCmd = ctlWr && cmdBits[CMD_START];
  assign stopCmd  = ctlWr && cmdBits[CMD_STOP];
  assign pdEntry  = (prevState == ST_ACTIVE) && (pwrState == ST_PWRDN);

  always_comb begin
    stb.wakeCfgWr = wrEn && (wrSel == SEL_WAKE_CFG);
    stb.wdogCfgWr = wrEn && (wrSel == SEL_WDOG_CFG);
    stb.wakeClr   = wrEn && (wrSel == SEL_WAKE_CLR) && cmdBits[CMD_CLR];
    stb.wdogClr   = wrEn && (wrSel == SEL_WDOG_CLR) && cmdBits[CMD_CLR];
    stb.wakeLoad  = ctlWr && cmdBits[CMD_LOAD];
    stb.wakeRun   = runQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevState <= ST_SLEEP;
      runQ      <= 1'b0;
    end else begin
      prevState <= pwrState;
      if (stopCmd)                 runQ <= 1'b0;
      else if (startCmd || pdEntry) runQ <= 1'b1;
    end
  end

  // R8: a stop command always disarms
  a_r8_stop_wins: assert property (@(posedge clk) disable iff (!rstN)
    stopCmd |=> !stb.wakeRun);
  // R2: an active-to-down edge arms the timer
  a_r2_entry_arms: assert property (@(posedge clk) disable iff (!rstN)
    pdEntry && !stopCmd |=> stb.wakeRun);
  // R3: arming only happens on an entry or a start
  a_r3_no_spurious_arm: assert property (@(posedge clk) disable iff (!rstN)
    !pdEntry && !startCmd && !stb.wakeRun |=> !stb.wakeRun);
endmodule

// File: rtl/lp_wake_dp.sv
module lp_wake_dp
  import lp_wake_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WAKE_W = 31,
  parameter int WDOG_W = 23,
  parameter int WDOG_LSB = 8,
  parameter int WDOG_THR_RST = 'hEA6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [DATA_W-1:0] wrData,
  output logic              wakeReq,
  output logic              wdogReq,
  output logic [WAKE_W-1:0] wakeCount,
  output logic [WDOG_W-1:0] wdogCount
);
  localparam int EN_BIT = DATA_W - 1;
  localparam int WDOG_MSB = WDOG_LSB + WDOG_W - 1;

  logic              wakeEn, wdogEn;
  logic [WAKE_W-1:0] wakeThr;
  logic [WDOG_W-1:0] wdogThr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeEn  <= 1'b0;
      wakeThr <= '0;
      wdogEn  <= 1'b1;
      wdogThr <= WDOG_W'(WDOG_THR_RST);
    end else begin
      if (stb.wakeCfgWr) begin
        wakeEn  <= wrData[EN_BIT];
        wakeThr <= wrData[WAKE_W-1:0];
      end
      if (stb.wdogCfgWr) begin
        wdogEn  <= wrData[EN_BIT];
        wdogThr <= wrData[WDOG_MSB:WDOG_LSB];
      end
    end
  end

  lp_cnt_unit #(.W(WAKE_W)) uWake (
    .clk(clk), .rstN(rstN),
    .en(stb.wakeRun && wakeEn),
    .clr(stb.wakeClr), .load(stb.wakeLoad),
    .thr(wakeThr), .cnt(wakeCount), .req(wakeReq)
  );

  lp_cnt_unit #(.W(WDOG_W)) uWdog (
    .clk(clk), .rstN(rstN),
    .en(wdogEn),
    .clr(stb.wdogClr), .load(1'b0),
    .thr(wdogThr), .cnt(wdogCount), .req(wdogReq)
  );

  // R9: watchdog counts from reset by default
  a_r9_wdog_runs: assert property (@(posedge clk) disable iff (!rstN)
    wdogEn && !wdogReq && !stb.wdogClr && (wdogCount < wdogThr) |=> wdogCount == $past(wdogCount) + WDOG_W'(1));
endmodule

// File: rtl/lp_wake_timer.sv
module lp_wake_timer
  import lp_wake_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STATE_W = 3,
  parameter int SEL_W = 3,
  parameter int WDOG_W = 23,
  parameter int WDOG_LSB = 8,
  parameter int WDOG_THR_RST = 'hEA6,
  parameter int LOAD_BIT = 16,
  parameter int STOP_BIT = 3,
  parameter int START_BIT = 2,
  parameter int CLR_BIT = 0,
  localparam int WAKE_W = DATA_W - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STATE_W-1:0] pwrState,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [DATA_W-1:0]  wrData,
  output logic               wakeReq,
  output logic               wdogReq,
  output logic [WAKE_W-1:0]  wakeCount,
  output logic [WDOG_W-1:0]  wdogCount
);
  strobeT stb;
  logic [3:0] cmdBits;

  assign cmdBits = {wrData[LOAD_BIT], wrData[STOP_BIT], wrData[START_BIT], wrData[CLR_BIT]};

  lp_wake_ctrl #(.STATE_W(STATE_W), .SEL_W(SEL_W), .CMD_W(4)) uCtrl (
    .clk(clk), .rstN(rstN), .pwrState(pwrState),
    .wrEn(wrEn), .wrSel(wrSel), .cmdBits(cmdBits), .stb(stb)
  );

  lp_wake_dp #(
    .DATA_W(DATA_W), .WAKE_W(WAKE_W), .WDOG_W(WDOG_W),
    .WDOG_LSB(WDOG_LSB), .WDOG_THR_RST(WDOG_THR_RST)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .wakeReq(wakeReq), .wdogReq(wdogReq),
    .wakeCount(wakeCount), .wdogCount(wdogCount)
  );
endmodule

// File: tb/sim_lp_wake_timer.sv
`timescale 1ns/1ps
module sim_lp_wake_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] pwrState = 3'b100;
  logic wrEn = 1'b0;
  logic [2:0] wrSel = 3'd0;
  logic [31:0] wrData = '0;
  logic wakeReq, wdogReq;
  logic [30:0] wakeCount;
  logic [22:0] wdogCount;

  int nChk = 0, nBad = 0;
  bit done = 1'b0;

  // reference model state
  longint mWc = 0, mWdc = 0, mWakeThr = 0, mWdogThr = 3750;
  bit mWq = 0, mDq = 0, mRun = 0, mWakeEn = 0, mWdogEn = 1;
  int mPrev = 4;

  always #4 clk = ~clk;

  lp_wake_timer u0 (
    .clk(clk), .rstN(rstN), .pwrState(pwrState), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .wakeReq(wakeReq), .wdogReq(wdogReq),
    .wakeCount(wakeCount), .wdogCount(wdogCount)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint floor2(input longint t);
    return (t < 2) ? 2 : t;
  endfunction

  task automatic model_step();
    bit wClr, dClr, ld, st, sp;
    if (!rstN) begin
      mWc = 0; mWdc = 0; mWq = 0; mDq = 0; mRun = 0; mPrev = 4;
      mWakeEn = 0; mWakeThr = 0; mWdogEn = 1; mWdogThr = 3750;
      return;
    end
    wClr = wrEn && wrSel == 2 && wrData[0];
    dClr = wrEn && wrSel == 4 && wrData[0];
    ld   = wrEn && wrSel == 1 && wrData[16];
    st   = wrEn && wrSel == 1 && wrData[2];
    sp   = wrEn && wrSel == 1 && wrData[3];
    if (wClr) begin mWc = 0; mWq = 0; end
    else if (ld) mWc = 2;
    else if (mRun && mWakeEn && !mWq) begin
      if (mWc >= floor2(mWakeThr)) mWq = 1; else mWc++;
    end
    if (dClr) begin mWdc = 0; mDq = 0; end
    else if (mWdogEn && !mDq) begin
      if (mWdc >= floor2(mWdogThr)) mDq = 1; else mWdc++;
    end
    if (sp) mRun = 0;
    else if (st || (mPrev == 3 && pwrState == 0)) mRun = 1;
    if (wrEn && wrSel == 0) begin mWakeEn = wrData[31]; mWakeThr = wrData[30:0]; end
    if (wrEn && wrSel == 3) begin mWdogEn = wrData[31]; mWdogThr = wrData[30:8]; end
    mPrev = pwrState;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R2 wakeCount", wakeCount, mWc);
    check("R4 wakeReq", wakeReq, mWq);
    check("R9 wdogCount", wdogCount, mWdc);
    check("R10 wdogReq", wdogReq, mDq);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    tick();
    wrEn = 1'b0; wrData = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    longint held;
    repeat (3) tick();
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    check("R1 wakeReq", wakeReq, 0);
    check("R1 wdogReq", wdogReq, 0);
    check("R1 wakeCount", wakeCount, 0);
    check("R1 wdogCount", wdogCount, 0);

    wr(3'd0, {1'b1, 31'd5});
    // R3: non-active entry into power-down does not arm
    pwrState = 3'b100; tick();
    pwrState = 3'b000; repeat (4) tick();
    check("R3 no arm", wakeCount, 0);

    // R2 / R4: real entry, count to threshold
    pwrState = 3'b011; tick();
    pwrState = 3'b000; tick();
    for (int i = 0; i < 20 && !wakeReq; i++) tick();
    check("R4 req set", wakeReq, 1);
    check("R4 count at thr", wakeCount, 5);
    repeat (3) tick();
    check("R4 sticky", wakeReq, 1);

    // R6 clear and resume
    wr(3'd2, 32'd1);
    check("R6 cleared req", wakeReq, 0);
    check("R6 cleared cnt", wakeCount, 0);
    repeat (2) tick();
    check("R6 resumes", wakeCount, 2);

    // R8 stop holds
    wr(3'd1, 32'h8);
    held = wakeCount;
    repeat (4) tick();
    check("R8 stopped", wakeCount, held);
    // R7 load
    wr(3'd1, 32'h1_0000);
    check("R7 load", wakeCount, 2);
    // R8 start
    wr(3'd1, 32'h4);
    tick();
    check("R8 started", wakeCount, 3);
    // R8 stop wins over start
    wr(3'd1, 32'hC);
    held = wakeCount;
    repeat (3) tick();
    check("R8 stop wins", wakeCount, held);
    wr(3'd1, 32'h4);

    // R5 clamp zero threshold
    wr(3'd0, {1'b1, 31'd0});
    wr(3'd2, 32'd1);
    for (int i = 0; i < 20 && !wakeReq; i++) tick();
    check("R5 clamp req", wakeReq, 1);
    check("R5 clamp cnt", wakeCount, 2);

    // R12 enable low holds
    wr(3'd2, 32'd1);
    wr(3'd0, {1'b0, 31'd9});
    held = wakeCount;
    repeat (5) tick();
    check("R12 hold", wakeCount, held);

    // R9 default watchdog threshold
    for (int i = 0; i < 5000 && !wdogReq; i++) tick();
    check("R9 wdog req", wdogReq, 1);
    check("R9 wdog count", wdogCount, 3750);
    // R10 clear
    wr(3'd4, 32'd1);
    check("R10 cleared", wdogReq, 0);
    check("R10 count zero", wdogCount, 0);
    repeat (3) tick();
    // R11 disable
    wr(3'd3, {1'b0, 23'd40, 8'd0});
    held = wdogCount;
    repeat (6) tick();
    check("R11 frozen", wdogCount, held);
    check("R11 no req", wdogReq, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule